// File: doc/BRIEF.md
# Pipelined FIR Multiply-Accumulate Engine

This block computes one output sample of a finite impulse response filter, y = sum over i from 0 to L-1 of b_i * x(n-i), for a tap count L between 1 and 64 given at start. The coefficient memory and the sample memory each have their own read port. On every active cycle the block drives the same tap index to both ports and receives both operands at once. Both memories answer in the same cycle the address is presented.

A full 16x16 signed multiplier writes its product into a pipeline register. An adder behind that register folds the previous cycle's product into a 40-bit accumulator, so multiplication and accumulation overlap. The operand index advances in the same cycle as the arithmetic. When the last product has been added, the accumulator is scaled back to Q15. Rounding is applied if it was requested. The value is saturated to 16 bits and written to a third, write-only result memory at the next result address. A one-cycle done pulse marks the write.

Operands and results are Q15 two's complement. The caller places b_i at coefficient address i and x(n-i) at sample address i.

Top module: `fir_mac_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, done_o, res_we_o and rd_en_o are 0 and res_addr_o is 0.
- R2: After a start is accepted, rd_en_o is 1 for exactly L consecutive cycles. In the k-th of these cycles (k from 0), coef_addr_o and samp_addr_o both equal k.
- R3: With rounding off, res_data_o equals floor(S / 2^15), where S is the exact sum of the L signed products, saturated as in R5.
- R4: With rounding on (round_i sampled with the accepted start), res_data_o equals floor((S + 2^14) / 2^15), saturated as in R5. An exact half rounds toward plus infinity.
- R5: A scaled result above 32767 is written as 32767 (0x7FFF). A scaled result below -32768 is written as -32768 (0x8000).
- R6: done_o and res_we_o are high together for exactly one cycle. They rise L+2 clock edges after the edge that accepted start.
- R7: A start asserted while the block is busy is ignored, along with any change to taps_i or round_i at that time. The running result is unaffected and no extra result is written.
- R8: Each accepted start clears the accumulator. A start in the cycle right after done gives a result that depends only on the new operands.
- R9: The first result after reset goes to address 0. Each write advances res_addr_o by one, wrapping modulo 2^RES_AW (16 by default).
- R10: L = 1 and L = 64 both give correct results and the timing of R6.
- R11: The accumulator holds partial sums of up to 64 full-scale products (about 2^36) without wrapping. Large partial sums that cancel give the exact small final result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to compute one output sample |
| taps_i | input | 7 | Tap count L (1 to 64), sampled with start |
| round_i | input | 1 | 1 = round on output, 0 = truncate; sampled with start |
| rd_en_o | output | 1 | Both operand addresses are valid this cycle |
| coef_addr_o | output | 6 | Coefficient memory read address |
| coef_data_i | input | 16 | Coefficient read data, same cycle |
| samp_addr_o | output | 6 | Sample memory read address |
| samp_data_i | input | 16 | Sample read data, same cycle |
| res_we_o | output | 1 | Result memory write enable |
| res_addr_o | output | 4 | Result memory write address |
| res_data_o | output | 16 | Result memory write data (Q15) |
| done_o | output | 1 | One-cycle pulse when the sample is finished |

## Verification
The hardest condition to reach is a start that lands in the middle of a busy run. It must change neither the latched tap count nor the rounding choice. It must also not add a second result write.

The bench drives start together with a different tap count partway through a run. It confirms the first result is unchanged. It then watches well past the point where a second pulse would appear.

Guard-bit behaviour is reached with 64 full-scale products of one sign, and with 32 positive and 32 negative products that cancel. Half-way rounding is reached with single-tap runs whose sum is exactly plus or minus 2^14.

// File: rtl/fir_mac_pkg.sv
// Package: shared widths for the FIR multiply-accumulate engine.
// Assumes Q15 operands and at most 64 taps.
package fir_mac_pkg;
    localparam int DATA_W  = 16;              // operand and result width
    localparam int ACC_W   = 40;              // accumulator width (8 guard bits)
    localparam int MAX_TAP = 64;              // largest tap count
    localparam int ADDR_W  = $clog2(MAX_TAP); // operand address width
    localparam int TAP_W   = ADDR_W + 1;      // width of the tap count
    localparam int RES_AW  = 4;               // result memory address width
endpackage

// File: rtl/fir_tap_seq.sv
// Module: fir_tap_seq
// Accepts a start when idle, latches the tap count and rounding choice,
// and steps the shared operand index through 0..L-1. It stays busy for the
// two pipeline cycles that follow, so starts are ignored until the result
// has been written. Assumes 1 <= taps_i <= MAX_TAP.
module fir_tap_seq #(
    parameter int ADDR_W = fir_mac_pkg::ADDR_W,
    parameter int TAP_W  = fir_mac_pkg::TAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TAP_W-1:0]  taps_i,
    input  logic              round_i,
    output logic              accept_o,
    output logic              fetch_en_o,
    output logic              fetch_last_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              round_o
);
    logic             busy_q;
    logic [TAP_W-1:0] cnt_q;
    logic [TAP_W-1:0] taps_q;
    logic             rnd_q;

    assign accept_o     = start_i && !busy_q;
    assign fetch_en_o   = busy_q && (cnt_q < taps_q);
    assign fetch_last_o = fetch_en_o && (cnt_q == taps_q - TAP_W'(1));
    assign idx_o        = cnt_q[ADDR_W-1:0];
    assign round_o      = rnd_q;

    // Run control: latch on accept, count through fetch and drain, then idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            taps_q <= '0;
            rnd_q  <= 1'b0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            taps_q <= taps_i;
            rnd_q  <= round_i;
        end else if (busy_q) begin
            if (cnt_q == taps_q + TAP_W'(1)) busy_q <= 1'b0;
            else                             cnt_q  <= cnt_q + TAP_W'(1);
        end
    end

    // R7: a start during a run leaves the count, tap count and rounding untouched.
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_q && cnt_q != taps_q + TAP_W'(1)) |=>
        (busy_q && cnt_q == $past(cnt_q) + TAP_W'(1) && taps_q == $past(taps_q)
         && rnd_q == $past(rnd_q)));

    // R2: the first fetch cycle after an accept addresses tap 0.
    assert_first_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (fetch_en_o && idx_o == '0));
endmodule

// File: rtl/fir_mac_dp.sv
// Module: fir_mac_dp
// Two-stage arithmetic: a single-cycle signed multiplier fills a product
// register, and the adder behind it adds that product into the accumulator
// one cycle later. Pulses acc_fin_o once the last product has been added.
// Assumes clear_i never coincides with a valid product.
module fir_mac_dp #(
    parameter int DATA_W = fir_mac_pkg::DATA_W,
    parameter int ACC_W  = fir_mac_pkg::ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     fetch_en_i,
    input  logic                     fetch_last_i,
    input  logic signed [DATA_W-1:0] coef_i,
    input  logic signed [DATA_W-1:0] samp_i,
    output logic signed [ACC_W-1:0]  acc_o,
    output logic                     acc_fin_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod_q;
    logic                     prod_vld_q;
    logic                     prod_last_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic                     fin_q;
    logic signed [ACC_W-1:0]  prod_ext;

    assign prod_ext  = {{EXT_W{prod_q[PROD_W-1]}}, prod_q};
    assign acc_o     = acc_q;
    assign acc_fin_o = fin_q;

    // Multiply stage: register the full product of this cycle's operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q      <= '0;
            prod_vld_q  <= 1'b0;
            prod_last_q <= 1'b0;
        end else begin
            if (fetch_en_i) prod_q <= coef_i * samp_i;
            prod_vld_q  <= fetch_en_i;
            prod_last_q <= fetch_last_i;
        end
    end

    // Accumulate stage: clear on start, else add the previous cycle's product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            fin_q <= 1'b0;
        end else begin
            if (clear_i)         acc_q <= '0;
            else if (prod_vld_q) acc_q <= acc_q + prod_ext;
            fin_q <= prod_last_q;
        end
    end

    // R8: an accepted start leaves a zero accumulator.
    assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_q == '0));

    // R6: the final-sum marker lasts one cycle.
    assert_fin_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);
endmodule

// File: rtl/fir_result_out.sv
// Module: fir_result_out
// Scales the final accumulator from Q30 to Q15. It can round half up
// first, then saturates to the operand width and registers one write
// into the result memory. The write address advances after every write.
// Assumes acc_i is stable during the cycle fin_i is high.
module fir_result_out #(
    parameter int DATA_W = fir_mac_pkg::DATA_W,
    parameter int ACC_W  = fir_mac_pkg::ACC_W,
    parameter int RES_AW = fir_mac_pkg::RES_AW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fin_i,
    input  logic                     round_i,
    input  logic signed [ACC_W-1:0]  acc_i,
    output logic                     we_o,
    output logic [RES_AW-1:0]        addr_o,
    output logic signed [DATA_W-1:0] data_o
);
    localparam int FRAC = DATA_W - 1;
    localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF = ONE <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ONE <<< FRAC) - ONE;
    localparam logic signed [ACC_W-1:0] MINV = -(ONE <<< FRAC);

    logic signed [ACC_W-1:0]  biased;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [DATA_W-1:0] clipped;
    logic                     we_q;
    logic [RES_AW-1:0]        addr_q;
    logic signed [DATA_W-1:0] data_q;

    // Rounding, scaling and saturation of the finished sum.
    always_comb begin
        biased = acc_i + (round_i ? HALF : '0);
        scaled = biased >>> FRAC;
        if (scaled > MAXV)      clipped = MAXV[DATA_W-1:0];
        else if (scaled < MINV) clipped = MINV[DATA_W-1:0];
        else                    clipped = scaled[DATA_W-1:0];
    end

    // Write register and result address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= fin_i;
            if (fin_i) data_q <= clipped;
            if (we_q)  addr_q <= addr_q + RES_AW'(1);
        end
    end

    assign we_o   = we_q;
    assign addr_o = addr_q;
    assign data_o = data_q;

    // R9: every write moves the result address on by one.
    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> (addr_q == $past(addr_q) + RES_AW'(1)));

    // R6: a write is always followed by a cycle without one.
    assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);
endmodule

// File: rtl/fir_mac_engine.sv
// Module: fir_mac_engine (top)
// One FIR output sample per start. It reads both operand memories through
// separate same-cycle ports, runs the two-stage multiply-accumulate, and
// writes the scaled result to a third memory with a done pulse.
// Assumes operand memories return data in the cycle the address is valid.
module fir_mac_engine #(
    parameter int DATA_W = fir_mac_pkg::DATA_W,
    parameter int ACC_W  = fir_mac_pkg::ACC_W,
    parameter int ADDR_W = fir_mac_pkg::ADDR_W,
    parameter int TAP_W  = fir_mac_pkg::TAP_W,
    parameter int RES_AW = fir_mac_pkg::RES_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TAP_W-1:0]  taps_i,
    input  logic              round_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] coef_addr_o,
    input  logic [DATA_W-1:0] coef_data_i,
    output logic [ADDR_W-1:0] samp_addr_o,
    input  logic [DATA_W-1:0] samp_data_i,
    output logic              res_we_o,
    output logic [RES_AW-1:0] res_addr_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              done_o
);
    logic                     accept;
    logic                     fetch_en;
    logic                     fetch_last;
    logic [ADDR_W-1:0]        idx;
    logic                     rnd;
    logic signed [ACC_W-1:0]  acc;
    logic                     acc_fin;
    logic                     we;
    logic signed [DATA_W-1:0] rdata;

    fir_tap_seq #(.ADDR_W(ADDR_W), .TAP_W(TAP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .taps_i(taps_i),
        .round_i(round_i), .accept_o(accept), .fetch_en_o(fetch_en),
        .fetch_last_o(fetch_last), .idx_o(idx), .round_o(rnd)
    );

    fir_mac_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .fetch_en_i(fetch_en),
        .fetch_last_i(fetch_last), .coef_i(coef_data_i), .samp_i(samp_data_i),
        .acc_o(acc), .acc_fin_o(acc_fin)
    );

    fir_result_out #(.DATA_W(DATA_W), .ACC_W(ACC_W), .RES_AW(RES_AW)) u_out (
        .clk(clk), .rst_n(rst_n), .fin_i(acc_fin), .round_i(rnd),
        .acc_i(acc), .we_o(we), .addr_o(res_addr_o), .data_o(rdata)
    );

    assign rd_en_o     = fetch_en;
    assign coef_addr_o = idx;
    assign samp_addr_o = idx;
    assign res_we_o    = we;
    assign res_data_o  = rdata;
    assign done_o      = we;

    // R2: the operand ports carry one shared index whenever they are read.
    assert_same_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (coef_addr_o == samp_addr_o));
endmodule

// File: tb/fir_mac_engine_test.sv
// Directed bench: each task runs one scenario and checks its own results.
module fir_mac_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  taps_i = 7'd1;
    logic        round_i = 1'b0;
    logic        rd_en_o, res_we_o, done_o;
    logic [5:0]  coef_addr_o, samp_addr_o;
    logic [15:0] coef_data_i, samp_data_i, res_data_o;
    logic [3:0]  res_addr_o;

    logic signed [15:0] cmem [0:63];
    logic signed [15:0] smem [0:63];
    int errors = 0;
    int checks = 0;
    int exp_addr = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    assign coef_data_i = cmem[coef_addr_o];
    assign samp_data_i = smem[samp_addr_o];

    fir_mac_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .taps_i(taps_i),
        .round_i(round_i), .rd_en_o(rd_en_o), .coef_addr_o(coef_addr_o),
        .coef_data_i(coef_data_i), .samp_addr_o(samp_addr_o),
        .samp_data_i(samp_data_i), .res_we_o(res_we_o), .res_addr_o(res_addr_o),
        .res_data_o(res_data_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic longint model(input int n, input bit rnd);
        longint s = 0;
        for (int i = 0; i < n; i++) s += longint'(cmem[i]) * longint'(smem[i]);
        if (rnd) s += 16384;
        s = s >>> 15;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) begin
            cmem[i] = 16'((i * 2311 + seed * 977) ^ 16'h5A5A);
            smem[i] = 16'((i * 4099 + seed * 313) ^ 16'h33C3);
        end
    endtask

    // One run from the current negedge; busy_at >= 0 injects an ignored start.
    task automatic run(input int n, input bit rnd, input int busy_at, input string req);
        longint exp = model(n, rnd);
        int bad_addr = 0;
        int early = 0;
        taps_i = 7'(n); round_i = rnd; start_i = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= n + 1; k++) begin
            @(negedge clk);
            start_i = (k == busy_at);
            if (k == busy_at) begin taps_i = 7'd3; round_i = !rnd; end
            if (rd_en_o !== (k < n)) bad_addr++;
            if (k < n && (coef_addr_o !== 6'(k) || samp_addr_o !== 6'(k))) bad_addr++;
            if (done_o !== 1'b0 || res_we_o !== 1'b0) early++;
            @(posedge clk);
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(bad_addr == 0, "R2 operand addresses", bad_addr, 0);
        chk(early == 0, "R6 no early done", early, 0);
        chk(done_o === 1'b1 && res_we_o === 1'b1, {req, " R6 done at L+2"}, done_o, 1);
        chk($signed(res_data_o) == exp, {req, " result"}, $signed(res_data_o), exp);
        chk(res_addr_o == 4'(exp_addr), "R9 result address", res_addr_o, exp_addr);
        exp_addr = (exp_addr + 1) % 16;
    endtask

    task automatic pulse_gone();
        @(posedge clk); @(negedge clk);
        chk(done_o === 1'b0 && res_we_o === 1'b0, "R6 single-cycle done", done_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done_o && !res_we_o && !rd_en_o && res_addr_o == 0, "R1 reset outputs", {done_o, res_we_o, rd_en_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !res_we_o && !rd_en_o && res_addr_o == 0, "R1 after release", {done_o, res_we_o, rd_en_o}, 0);
    endtask

    task automatic t_basic();
        fill(1);
        run(8, 1'b0, -1, "R3 truncate L=8");
        run(8, 1'b1, -1, "R4 round L=8");
        fill(2);
        run(13, 1'b0, -1, "R3 truncate L=13");
    endtask

    task automatic t_round_half();
        fill(0);
        cmem[0] = 16'sd16384; smem[0] = 16'sd1;
        run(1, 1'b0, -1, "R4 half truncates to 0");
        run(1, 1'b1, -1, "R4 half rounds up to 1");
        cmem[0] = -16'sd16384;
        run(1, 1'b0, -1, "R4 minus half truncates to -1");
        run(1, 1'b1, -1, "R4 minus half rounds to 0");
    endtask

    task automatic t_boundaries();
        fill(3);
        run(1, 1'b0, -1, "R10 L=1");
        run(64, 1'b1, -1, "R10 L=64");
        pulse_gone();
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 64; i++) begin cmem[i] = -16'sd32768; smem[i] = -16'sd32768; end
        run(64, 1'b0, -1, "R5 positive saturation");
        for (int i = 0; i < 64; i++) begin cmem[i] = 16'sd32767; smem[i] = -16'sd32768; end
        run(64, 1'b1, -1, "R5 negative saturation");
    endtask

    task automatic t_guard();
        for (int i = 0; i < 64; i++) begin
            cmem[i] = (i < 32) ? 16'sd32767 : -16'sd32767;
            smem[i] = 16'sd32767;
        end
        cmem[63] = -16'sd32000;
        run(64, 1'b0, -1, "R11 cancelling partial sums");
    endtask

    task automatic t_busy_start();
        fill(4);
        run(10, 1'b0, 4, "R7 start while busy");
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); @(negedge clk);
            if (done_o) begin
                chk(1'b0, "R7 no extra result", 1, 0);
                break;
            end
        end
        chk(res_addr_o == 4'(exp_addr), "R7 no extra write", res_addr_o, exp_addr);
    endtask

    task automatic t_back_to_back();
        fill(5);
        run(6, 1'b0, -1, "R8 first run");
        fill(6);
        run(6, 1'b0, -1, "R8 immediate restart clears sum");
    endtask

    task automatic t_wrap();
        fill(7);
        for (int r = 0; r < 18; r++) run(2, r[0], -1, "R9 wrap sequence");
    endtask

    initial begin
        fill(0);
        t_reset();
        t_basic();
        t_round_half();
        t_boundaries();
        t_saturate();
        t_guard();
        t_busy_start();
        t_back_to_back();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule